// File: doc/BRIEF.md
# Virtual-Address Line Cache with Per-Mode Valid Bits

This block is a direct-mapped cache that sits beside address translation. It is indexed and tagged with the virtual address, so the lookup does not wait for translation. The translated physical address and the page's cache-inhibit flag arrive with the request, and both are used only on the memory side. A line holds one 32-bit word. That word may be an instruction or data, and it may belong to user or to supervisor space. Every line carries two valid bits, one for each privilege mode. A hit needs the tag to match and the valid bit of the requesting mode to be set.

Invalidation has no command of its own. It follows register-side events. Any change of the cache enable level drops every line in both modes. A write pulse to the user segment table pointer drops all user lines. A write pulse to the supervisor pointer drops all supervisor lines. A read miss fills the line from the backing memory port. Writes always go through to memory. Inhibited accesses, and all accesses while the cache is disabled, go around the array.

The request side uses valid/ready. A request is held until `req_ready` is seen high, and `req_ready` is high only when no access is outstanding. The completion is a single-cycle `rsp_valid` pulse with no back-pressure. On the memory side, `mem_req_valid` and its fields stay stable until `mem_req_ready` is seen. `mem_rsp_valid` is a one-cycle pulse that the block always accepts.

Top module: `vcache_top`

## Requirements
- R1: `req_ready` is high exactly when no access is outstanding. A request is taken on `req_valid && req_ready`. Each taken request produces exactly one `rsp_valid` pulse, and no new request is taken before it.
- R2: A read is a hit when it is cacheable, the line at index `va[IDX+1:2]` holds tag `va[31:IDX+2]`, and the valid bit of the requesting mode is set. A hit completes with `rsp_valid` and the line data in the cycle after acceptance, with no memory request.
- R3: Any access that is not a read hit drives one memory request at `req_pa`. `mem_req_valid`, `mem_req_addr`, `mem_req_write` and `mem_req_wdata` are held stable until `mem_req_ready`. `rsp_valid` rises in the same cycle as `mem_rsp_valid`, and for reads it carries `mem_rsp_rdata`.
- R4: A fill writes tag and data, sets the valid bit of the requesting mode, and clears the other mode's valid bit for that line. A line is therefore never valid in both modes at once.
- R5: A line that is valid only for one mode misses for the other mode. Two addresses with the same index and different tags evict each other.
- R6: A write always goes to memory with `mem_req_write=1` and `req_wdata`. On a hit in the current mode the line data is replaced. A write miss allocates nothing. Writes respond with `rsp_rdata=0`.
- R7: A request with `req_inhibit=1` never hits, even when its line is present, and never changes the array.
- R8: While `cache_enable` is 0 every access bypasses the array. Any change of `cache_enable`, in either direction, invalidates all lines in both modes from the next cycle on.
- R9: A `usr_ptr_wr` pulse clears every user valid bit and leaves supervisor lines usable.
- R10: A `sup_ptr_wr` pulse clears every supervisor valid bit and leaves user lines usable.
- R11: If the requesting mode's valid bits are cleared at any point from acceptance up to and including the memory response cycle, that read miss does not allocate. A clear aimed at the other mode does not prevent the fill.
- R12: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_super | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_inhibit | input | 1 | Page is cache-inhibited (from translation) |
| req_va | input | 32 | Virtual address (bits 1:0 ignored) |
| req_pa | input | 32 | Translated physical address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, zero for writes |
| mem_req_valid | output | 1 | Backing memory request |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Memory address (physical) |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory completion pulse |
| mem_rsp_rdata | input | 32 | Memory read data |
| cache_enable | input | 1 | Cache enable level; any change flushes all lines |
| usr_ptr_wr | input | 1 | User table pointer written: flush user lines |
| sup_ptr_wr | input | 1 | Supervisor table pointer written: flush supervisor lines |

## Verification
The hardest case to reach is a flush that lands while a read miss is in flight. If that fill were allowed, it would install a line fetched through a mapping that has since been dropped. The stimulus task places a pointer-write pulse or an enable toggle at a chosen cycle offset inside an access, while the memory model stretches the request with ready stalls and response latency. This covers both the window between acceptance and the memory handshake and the response cycle itself. The same address is then read again so that any wrongly kept line shows up as a missing memory request. The same address is also used from both modes with different physical mappings, so a cross-mode hit returns visibly wrong data.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int VA_W   = 32;
  localparam int DATA_W = 32;
  localparam int OFF_W  = $clog2(DATA_W / 8);

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOOK,
    PH_MREQ,
    PH_MWAIT
  } phase_e;

  typedef struct packed {
    logic                    wr;
    logic                    sup;
    logic                    cach;
    logic [VA_W-1:OFF_W]     va;
    logic [VA_W-1:0]         pa;
    logic [DATA_W-1:0]       wdata;
  } acc_t;
endpackage

// File: rtl/vc_flush_gen.sv
module vc_flush_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic en_lvl,
  input  logic usr_wr,
  input  logic sup_wr,
  output logic en_flip,
  output logic clr_usr,
  output logic clr_sup
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_lvl;
  end

  // either edge of the enable level drops everything
  assign en_flip = en_lvl ^ en_q;
  assign clr_usr = usr_wr | en_flip;
  assign clr_sup = sup_wr | en_flip;
endmodule

// File: rtl/vc_valid_bits.sv
module vc_valid_bits #(
  parameter int LINES = 4096,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_sup,
  input  logic             clr_usr,
  input  logic             clr_sup,
  output logic [LINES-1:0] usr_vld,
  output logic [LINES-1:0] sup_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_vld <= '0;
      sup_vld <= '0;
    end else begin
      if (wr_en) begin
        // owner mode gets the line, the other mode loses it
        usr_vld[wr_idx] <= !wr_sup;
        sup_vld[wr_idx] <= wr_sup;
      end
      // bulk clears win over a same-cycle line write
      if (clr_usr) usr_vld <= '0;
      if (clr_sup) sup_vld <= '0;
    end
  end
endmodule

// File: rtl/vc_line_store.sv
module vc_line_store #(
  parameter int LINES = 4096,
  parameter int TAG_W = 18,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [DW-1:0]    w_data,
  input  logic [IDX_W-1:0] r_idx,
  output logic [TAG_W-1:0] r_tag,
  output logic [DW-1:0]    r_data
);
  logic [TAG_W-1:0] tag_mem  [LINES];
  logic [DW-1:0]    data_mem [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[w_idx]  <= w_tag;
      data_mem[w_idx] <= w_data;
    end
  end

  assign r_tag  = tag_mem[r_idx];
  assign r_data = data_mem[r_idx];
endmodule

// File: rtl/vc_ctrl.sv
module vc_ctrl
  import vc_pkg::*;
#(
  parameter int LINES = 4096,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = VA_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_super,
  input  logic              req_inhibit,
  input  logic [VA_W-1:OFF_W] req_va_w,
  input  logic [VA_W-1:0]   req_pa,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [VA_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata,
  input  logic              en_lvl,
  input  logic              clr_usr,
  input  logic              clr_sup,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [DATA_W-1:0] lk_data,
  input  logic              lk_usr_vld,
  input  logic              lk_sup_vld,
  output logic              lw_en,
  output logic [TAG_W-1:0]  lw_tag,
  output logic [DATA_W-1:0] lw_data,
  output logic              lw_sup
);
  phase_e ph_q;
  acc_t   cur_q;
  logic   kill_q;

  logic accept, clr_mine, clr_in, vld_mine, line_match, fill_ok;
  logic [TAG_W-1:0] cur_tag;

  assign req_ready = (ph_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  assign lk_idx   = cur_q.va[IDX_W+OFF_W-1:OFF_W];
  assign cur_tag  = cur_q.va[VA_W-1:IDX_W+OFF_W];
  assign clr_mine = cur_q.sup ? clr_sup : clr_usr;
  assign clr_in   = req_super ? clr_sup : clr_usr;
  assign vld_mine = cur_q.sup ? lk_sup_vld : lk_usr_vld;

  // a line being flushed this very cycle is already gone
  assign line_match = cur_q.cach && vld_mine && (lk_tag == cur_tag) && !clr_mine;
  assign fill_ok    = !cur_q.wr && cur_q.cach && !kill_q && !clr_mine;

  assign mem_req_addr  = cur_q.pa;
  assign mem_req_write = cur_q.wr;
  assign mem_req_wdata = cur_q.wdata;
  assign lw_tag        = cur_tag;
  assign lw_sup        = cur_q.sup;

  always_comb begin
    rsp_valid     = 1'b0;
    rsp_rdata     = '0;
    mem_req_valid = 1'b0;
    lw_en         = 1'b0;
    lw_data       = cur_q.wdata;
    unique case (ph_q)
      PH_LOOK: begin
        if (!cur_q.wr && line_match) begin
          rsp_valid = 1'b1;
          rsp_rdata = lk_data;
        end else begin
          mem_req_valid = 1'b1;
          lw_en         = cur_q.wr && line_match;
        end
      end
      PH_MREQ: mem_req_valid = 1'b1;
      PH_MWAIT: begin
        if (mem_rsp_valid) begin
          rsp_valid = 1'b1;
          rsp_rdata = cur_q.wr ? '0 : mem_rsp_rdata;
          lw_en     = fill_ok;
          lw_data   = mem_rsp_rdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cur_q  <= '0;
      kill_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (accept) begin
            cur_q.wr    <= req_write;
            cur_q.sup   <= req_super;
            cur_q.cach  <= en_lvl && !req_inhibit;
            cur_q.va    <= req_va_w;
            cur_q.pa    <= req_pa;
            cur_q.wdata <= req_wdata;
            kill_q      <= clr_in;
            ph_q        <= PH_LOOK;
          end
        end
        PH_LOOK: begin
          kill_q <= kill_q | clr_mine;
          if (!cur_q.wr && line_match) ph_q <= PH_IDLE;
          else if (mem_req_ready)      ph_q <= PH_MWAIT;
          else                         ph_q <= PH_MREQ;
        end
        PH_MREQ: begin
          kill_q <= kill_q | clr_mine;
          if (mem_req_ready) ph_q <= PH_MWAIT;
        end
        PH_MWAIT: begin
          kill_q <= kill_q | clr_mine;
          if (mem_rsp_valid) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcache_top.sv
module vcache_top
  import vc_pkg::*;
#(
  parameter int CACHE_BYTES = 16384,
  localparam int LINES = CACHE_BYTES / (DATA_W / 8),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = VA_W - IDX_W - OFF_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_super,
  input  logic        req_inhibit,
  input  logic [31:0] req_va,
  input  logic [31:0] req_pa,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_rdata,
  input  logic        cache_enable,
  input  logic        usr_ptr_wr,
  input  logic        sup_ptr_wr
);
  logic             en_flip, clr_usr, clr_sup;
  logic [LINES-1:0] usr_vld, sup_vld;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag, lw_tag;
  logic [31:0]      lk_data, lw_data;
  logic             lw_en, lw_sup;
  logic             unused_lo;

  assign unused_lo = ^req_va[OFF_W-1:0];

  vc_flush_gen flush_i (
    .clk(clk), .rst_n(rst_n), .en_lvl(cache_enable),
    .usr_wr(usr_ptr_wr), .sup_wr(sup_ptr_wr),
    .en_flip(en_flip), .clr_usr(clr_usr), .clr_sup(clr_sup)
  );

  vc_valid_bits #(.LINES(LINES)) vld_i (
    .clk(clk), .rst_n(rst_n), .wr_en(lw_en), .wr_idx(lk_idx), .wr_sup(lw_sup),
    .clr_usr(clr_usr), .clr_sup(clr_sup), .usr_vld(usr_vld), .sup_vld(sup_vld)
  );

  vc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DW(DATA_W)) store_i (
    .clk(clk), .we(lw_en), .w_idx(lk_idx), .w_tag(lw_tag), .w_data(lw_data),
    .r_idx(lk_idx), .r_tag(lk_tag), .r_data(lk_data)
  );

  vc_ctrl #(.LINES(LINES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_super(req_super), .req_inhibit(req_inhibit),
    .req_va_w(req_va[VA_W-1:OFF_W]), .req_pa(req_pa), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .en_lvl(cache_enable),
    .clr_usr(clr_usr), .clr_sup(clr_sup),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_data(lk_data),
    .lk_usr_vld(usr_vld[lk_idx]), .lk_sup_vld(sup_vld[lk_idx]),
    .lw_en(lw_en), .lw_tag(lw_tag), .lw_data(lw_data), .lw_sup(lw_sup)
  );
endmodule

// File: rtl/vcache_chk.sv
module vcache_chk #(
  parameter int LINES = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [31:0]      mem_req_addr,
  input logic [31:0]      mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic [LINES-1:0] usr_vld,
  input logic [LINES-1:0] sup_vld,
  input logic             clr_usr,
  input logic             clr_sup,
  input logic             en_flip
);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  rsp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !mem_rsp_valid) |-> !mem_req_valid);

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  // R4
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_vld & sup_vld) == '0);

  // R8
  en_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_flip |=> (usr_vld == '0 && sup_vld == '0));

  // R9
  usr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_usr |=> usr_vld == '0);

  // R10
  sup_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sup |=> sup_vld == '0);
endmodule

bind vcache_top vcache_chk #(.LINES(LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .usr_vld(usr_vld), .sup_vld(sup_vld), .clr_usr(clr_usr), .clr_sup(clr_sup),
  .en_flip(en_flip)
);

// File: tb/vcache_top_tb_top.sv
`timescale 1ns/1ps
module vcache_top_tb_top;
  localparam int CAP = 16384;
  localparam int NL  = CAP / 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_super, req_inhibit;
  logic [31:0] req_va, req_pa, req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        cache_enable, usr_ptr_wr, sup_ptr_wr;

  vcache_top #(.CACHE_BYTES(CAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_super(req_super), .req_inhibit(req_inhibit),
    .req_va(req_va), .req_pa(req_pa), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .cache_enable(cache_enable),
    .usr_ptr_wr(usr_ptr_wr), .sup_ptr_wr(sup_ptr_wr)
  );

  int total = 0, bad = 0;
  string tag_s = "R12";

  // behavioural reference: 0 free, 1 lookup, 2 waiting for memory ready, 3 waiting for data
  int          ph;
  bit          m_wr, m_sup, m_cach, m_kill;
  logic [31:0] m_va, m_pa, m_wd;
  logic [31:0] c_tag [int];
  logic [31:0] c_dat [int];
  bit          c_u [int];
  bit          c_s [int];
  bit          en_prev;
  logic [31:0] bmem [int];
  bit          mp_pend;
  int          mp_cnt, lat_cfg, stall_mode, cyc;
  logic [31:0] mp_data;

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    if (bmem.exists(a)) return bmem[a];
    return {a[15:0], ~a[31:16]};
  endfunction

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic mem_take();
    mp_pend = 1'b1;
    mp_cnt  = lat_cfg;
    if (m_wr) bmem[m_pa] = m_wd;
    mp_data = m_wr ? 32'h0 : rd_mem(m_pa);
  endtask

  task automatic cycle();
    int i;
    bit clr_u, clr_s, clr_m, vld, hit;
    mem_rsp_valid = mp_pend && (mp_cnt == 0);
    mem_rsp_rdata = mp_pend ? mp_data : 32'hBAD0_BAD0;
    case (stall_mode)
      0: mem_req_ready = 1'b1;
      1: mem_req_ready = (cyc % 3 == 2);
      2: mem_req_ready = (cyc % 2 == 0);
      default: mem_req_ready = $urandom % 2;
    endcase
    #1;
    clr_u = usr_ptr_wr || (cache_enable != en_prev);
    clr_s = sup_ptr_wr || (cache_enable != en_prev);
    clr_m = m_sup ? clr_s : clr_u;
    i     = (m_va >> 2) % NL;
    vld   = m_sup ? (c_s.exists(i) && c_s[i]) : (c_u.exists(i) && c_u[i]);
    hit   = m_cach && vld && c_tag.exists(i) && (c_tag[i] == m_va / CAP) && !clr_m;
    // R1: ready only when nothing is outstanding
    chk("R1", {31'b0, req_ready}, {31'b0, ph == 0});
    if (ph == 1) begin
      chk(tag_s, {31'b0, rsp_valid}, {31'b0, !m_wr && hit});
      chk(tag_s, {31'b0, mem_req_valid}, {31'b0, !(!m_wr && hit)});
      if (!m_wr && hit && rsp_valid) chk(tag_s, rsp_rdata, c_dat[i]);
    end else if (ph == 2) begin
      chk("R3", {31'b0, mem_req_valid}, 32'd1);
      chk("R3", {31'b0, rsp_valid}, 32'd0);
    end else if (ph == 3) begin
      chk("R3", {31'b0, mem_req_valid}, 32'd0);
      chk("R3", {31'b0, rsp_valid}, {31'b0, mem_rsp_valid});
      if (mem_rsp_valid) chk(m_wr ? "R6" : "R3", rsp_rdata, m_wr ? 32'h0 : mp_data);
    end else begin
      chk("R1", {31'b0, rsp_valid}, 32'd0);
      chk("R1", {31'b0, mem_req_valid}, 32'd0);
    end
    if (mem_req_valid && (ph == 1 || ph == 2)) begin
      chk(m_wr ? "R6" : "R3", mem_req_addr, m_pa);
      chk("R6", {31'b0, mem_req_write}, {31'b0, m_wr});
      if (m_wr) chk("R6", mem_req_wdata, m_wd);
    end
    // advance the reference across the coming edge
    case (ph)
      0: if (req_valid) begin
        m_wr = req_write; m_sup = req_super; m_va = req_va; m_pa = req_pa; m_wd = req_wdata;
        m_cach = cache_enable && !req_inhibit;
        m_kill = req_super ? clr_s : clr_u;
        ph = 1;
      end
      1: begin
        m_kill |= clr_m;
        if (!m_wr && hit) ph = 0;
        else begin
          if (m_wr && hit) begin
            c_dat[i] = m_wd; c_u[i] = !m_sup; c_s[i] = m_sup;
          end
          if (mem_req_ready) begin mem_take(); ph = 3; end
          else ph = 2;
        end
      end
      2: begin
        m_kill |= clr_m;
        if (mem_req_ready) begin mem_take(); ph = 3; end
      end
      default: begin
        if (mem_rsp_valid) begin
          if (!m_wr && m_cach && !m_kill && !clr_m) begin
            c_tag[i] = m_va / CAP; c_dat[i] = mp_data; c_u[i] = !m_sup; c_s[i] = m_sup;
          end
          mp_pend = 1'b0;
          ph = 0;
        end else begin
          m_kill |= clr_m;
          if (mp_cnt > 0) mp_cnt--;
        end
      end
    endcase
    if (clr_u) c_u.delete();
    if (clr_s) c_s.delete();
    en_prev = cache_enable;
    cyc++;
    @(negedge clk);
  endtask

  // pulse kind: 1 user pointer write, 2 supervisor pointer write, 3 enable toggle
  task automatic set_pulse(input int kind, input bit on);
    if (kind == 1) usr_ptr_wr = on;
    if (kind == 2) sup_ptr_wr = on;
    if (kind == 3 && on) cache_enable = ~cache_enable;
  endtask

  task automatic acc(input bit wr, input bit sup, input bit inh, input logic [31:0] va,
                     input logic [31:0] wd, input int pulse_at, input int kind);
    int k = 0;
    req_valid = 1'b1; req_write = wr; req_super = sup; req_inhibit = inh;
    req_va = va; req_pa = va + (sup ? 32'h4000_0000 : 32'h0); req_wdata = wd;
    do begin
      bit was_free = (ph == 0);
      if (k == pulse_at) set_pulse(kind, 1'b1);
      cycle();
      set_pulse(kind, 1'b0);
      if (was_free) req_valid = 1'b0;
      k++;
    end while (ph != 0 || req_valid);
  endtask

  task automatic idle_pulse(input int kind);
    set_pulse(kind, 1'b1);
    cycle();
    set_pulse(kind, 1'b0);
  endtask

  localparam logic [31:0] A = 32'h0000_1000;
  localparam logic [31:0] B = A + CAP;
  localparam logic [31:0] C = 32'h0000_2004;
  localparam logic [31:0] D = 32'h0000_3FF0;
  localparam logic [31:0] E = 32'h0000_0800;
  localparam logic [31:0] F = 32'h0000_0C40;

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_super = 0; req_inhibit = 0;
    req_va = 0; req_pa = 0; req_wdata = 0; mem_req_ready = 0; mem_rsp_valid = 0;
    mem_rsp_rdata = 0; cache_enable = 1'b1; usr_ptr_wr = 0; sup_ptr_wr = 0;
    ph = 0; en_prev = 0; mp_pend = 0; mp_cnt = 0; lat_cfg = 1; stall_mode = 0; cyc = 0;
    m_wr = 0; m_sup = 0; m_cach = 0; m_kill = 0; m_va = 0; m_pa = 0; m_wd = 0; mp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12: reset state at the ports
    chk("R12", {31'b0, req_ready}, 32'd1);
    chk("R12", {31'b0, rsp_valid}, 32'd0);
    chk("R12", {31'b0, mem_req_valid}, 32'd0);
    @(negedge clk);
    cycle();
    tag_s = "R12"; acc(0, 0, 0, A, 0, -1, 0);      // nothing valid after reset
    tag_s = "R2";  acc(0, 0, 0, A, 0, -1, 0);      // now a hit
    stall_mode = 1; lat_cfg = 2;
    tag_s = "R3";  acc(0, 0, 0, C, 0, -1, 0);
    tag_s = "R5";  acc(0, 1, 0, A, 0, -1, 0);      // supervisor misses a user line
    tag_s = "R4";  acc(0, 0, 0, A, 0, -1, 0);      // supervisor fill took the line away
    tag_s = "R5";  acc(0, 0, 0, B, 0, -1, 0);      // same index, other tag
    acc(0, 0, 0, A, 0, -1, 0);
    tag_s = "R6";  acc(1, 0, 0, A, 32'hCAFE_0001, -1, 0);
    acc(0, 0, 0, A, 0, -1, 0);
    acc(1, 0, 0, D, 32'h1234_5678, -1, 0);
    acc(0, 0, 0, D, 0, -1, 0);
    tag_s = "R7";  acc(0, 0, 1, A, 0, -1, 0);
    acc(1, 0, 1, A, 32'h7777_0000, -1, 0);
    acc(0, 0, 0, A, 0, -1, 0);
    acc(0, 0, 1, F, 0, -1, 0);
    acc(0, 0, 0, F, 0, -1, 0);
    tag_s = "R8";  idle_pulse(3);
    acc(0, 0, 0, A, 0, -1, 0);
    acc(0, 0, 0, A, 0, -1, 0);
    idle_pulse(3);
    acc(0, 0, 0, A, 0, -1, 0);
    acc(0, 0, 0, A, 0, -1, 0);
    tag_s = "R9";  acc(0, 1, 0, E, 0, -1, 0);
    idle_pulse(1);
    acc(0, 0, 0, A, 0, -1, 0);
    acc(0, 1, 0, E, 0, -1, 0);
    tag_s = "R10"; idle_pulse(2);
    acc(0, 1, 0, E, 0, -1, 0);
    acc(0, 0, 0, A, 0, -1, 0);
    stall_mode = 2; lat_cfg = 3;
    tag_s = "R11";
    for (int p = 0; p < 5; p++) begin
      acc(0, 0, 0, F, 0, p, 1);
      acc(0, 0, 0, F, 0, -1, 0);
      acc(0, 1, 0, F, 0, p, 2);
      acc(0, 0, 0, F, 0, -1, 0);
      acc(0, 1, 0, F, 0, p, 1);
      acc(0, 1, 0, F, 0, -1, 0);
    end
    tag_s = "R5";
    for (int n = 0; n < 500; n++) begin
      logic [31:0] vas [6] = '{A, B, C, C + 2 * CAP, D, D + 3 * CAP};
      int pk = ($urandom % 10 == 0) ? 1 + $urandom % 3 : 0;
      stall_mode = n % 4;
      lat_cfg = $urandom % 3;
      acc($urandom % 4 == 0, $urandom % 2, $urandom % 8 == 0, vas[$urandom % 6],
          $urandom, pk != 0 ? $urandom % 4 : -1, pk);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(190000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule